// File: doc/BRIEF.md
# Least-Squares Training-Symbol Channel Estimator

This block produces per-subcarrier channel estimates for a multi-antenna link that trains one transmit/receive beam pair per OFDM training symbol. Each training symbol is the standard long training sequence, whose active subcarriers carry only +1 or -1. The least-squares estimate (received value divided by known value) is therefore either the sample itself or its negation. No divider or multiplier is needed.

A controller pulses `start` together with the number of training symbols taken from the training frame's signal field. Up to four antennas per side are supported, which gives at most 16 symbols. The FFT then streams 64 bins per symbol in natural bin order, one complex sample per `in_valid` cycle. The block drops the DC and guard bins. For each of the 52 active subcarriers it emits one registered estimate tagged with the beam-pair index and the active-subcarrier index. It raises a last flag on the final estimate of the final symbol and then returns to idle.

Top module: `chest_ls_est`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, `out_valid` and `out_last` are 0.
- R2: `start` while idle loads the symbol count from `sym_count`. A value of 0 is treated as 1, and a value above 16 is treated as 16.
- R3: Within each symbol, input bins are numbered 0..63 in arrival order. Bin 0 and bins 27..37 produce no output.
- R4: An accepted active bin produces `out_valid` on the next clock edge. `out_sub` = bin-1 for bins 1..26 and bin-12 for bins 38..63.
- R5: When bit `out_sub` of parameter NEG_MASK is 1, both components are negated. Otherwise they pass through unchanged. The default mask, 52'h0A605302B3EA6, encodes the long training sequence, with bit j set where subcarrier j carries -1.
- R6: Negating -128 yields +127.
- R7: `out_pair` equals the zero-based index of the current training symbol, which runs from 0 to count-1.
- R8: `out_last` is 1 only on `out_sub` 51 of the final symbol. After it, the block is idle and produces no output until the next `start`.
- R9: Samples arriving while idle produce no output. A `start` arriving while busy has no effect.
- R10: A cycle with `in_valid` low does not advance the bin position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a training sequence |
| sym_count | input | 5 | Number of training symbols (beam pairs) |
| in_valid | input | 1 | FFT sample valid |
| in_re | input | 8 | FFT sample real part, two's complement |
| in_im | input | 8 | FFT sample imaginary part, two's complement |
| out_valid | output | 1 | Estimate valid |
| out_re | output | 8 | Estimate real part |
| out_im | output | 8 | Estimate imaginary part |
| out_pair | output | 4 | Beam-pair index |
| out_sub | output | 6 | Active-subcarrier index 0..51 |
| out_last | output | 1 | Final estimate of the sequence |

## Verification
A wrong bin counter shows at the ports within one symbol. Estimates appear on a guard bin, `out_sub` is skewed, or the sign pattern misaligns, and each of these is caught on the first affected sample. A wrong pair counter or count clamp shows as a wrong `out_pair`, a misplaced `out_last`, or output that continues or stops one symbol early. The bench catches this at the symbol boundary by streaming extra symbols beyond the loaded count and requiring silence. Saturation and stall faults show on the very next sample.

// File: rtl/chest_pkg.sv
package chest_pkg;
    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} chest_state_e;
endpackage

// File: rtl/chest_bin_map.sv
module chest_bin_map #(
    parameter int NFFT = 64,
    parameter int HALF = 26,
    localparam int BW   = $clog2(NFFT),
    localparam int SUBW = $clog2(2 * HALF)
) (
    input  logic [BW-1:0]   bin,
    output logic            active,
    output logic [SUBW-1:0] sub
);
    localparam int NEG_START = NFFT - HALF;
    localparam int GAP       = NFFT - 2 * HALF;

    always_comb begin
        active = 1'b0;
        sub    = '0;
        if (int'(bin) >= 1 && int'(bin) <= HALF) begin
            active = 1'b1;
            sub    = SUBW'(int'(bin) - 1);
        end else if (int'(bin) >= NEG_START) begin
            active = 1'b1;
            sub    = SUBW'(int'(bin) - GAP);
        end
    end
endmodule

// File: rtl/chest_neg.sv
module chest_neg #(
    parameter int SW = 8
) (
    input  logic          neg,
    input  logic [SW-1:0] din,
    output logic [SW-1:0] dout
);
    localparam logic [SW-1:0] MINV = {1'b1, {(SW-1){1'b0}}};
    localparam logic [SW-1:0] MAXV = {1'b0, {(SW-1){1'b1}}};

    always_comb begin
        if (!neg)             dout = din;
        else if (din == MINV) dout = MAXV;
        else                  dout = (~din) + 1'b1;
    end
endmodule

// File: rtl/chest_ls_est.sv
module chest_ls_est
    import chest_pkg::*;
#(
    parameter int SW   = 8,
    parameter int NFFT = 64,
    parameter int HALF = 26,
    parameter int MAXP = 16,
    parameter logic [2*HALF-1:0] NEG_MASK = 52'h0A605302B3EA6,
    localparam int BW   = $clog2(NFFT),
    localparam int NACT = 2 * HALF,
    localparam int SUBW = $clog2(NACT),
    localparam int PW   = $clog2(MAXP),
    localparam int CW   = PW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CW-1:0]   sym_count,
    input  logic            in_valid,
    input  logic [SW-1:0]   in_re,
    input  logic [SW-1:0]   in_im,
    output logic            out_valid,
    output logic [SW-1:0]   out_re,
    output logic [SW-1:0]   out_im,
    output logic [PW-1:0]   out_pair,
    output logic [SUBW-1:0] out_sub,
    output logic            out_last
);
    typedef struct packed {
        chest_state_e    st;
        logic [BW-1:0]   bin;
        logic [PW-1:0]   pair;
        logic [PW-1:0]   last_pair;
        logic            ov;
        logic [SW-1:0]   ore;
        logic [SW-1:0]   oim;
        logic [PW-1:0]   opair;
        logic [SUBW-1:0] osub;
        logic            olast;
    } est_state_t;

    est_state_t q, d;

    logic            act;
    logic [SUBW-1:0] sub;
    logic [SW-1:0]   comp_in  [2];
    logic [SW-1:0]   comp_out [2];

    chest_bin_map #(.NFFT(NFFT), .HALF(HALF)) u_map (
        .bin(q.bin), .active(act), .sub(sub)
    );

    assign comp_in[0] = in_re;
    assign comp_in[1] = in_im;

    for (genvar c = 0; c < 2; c++) begin : g_comp
        chest_neg #(.SW(SW)) u_neg (
            .neg(NEG_MASK[sub]), .din(comp_in[c]), .dout(comp_out[c])
        );
    end

    always_comb begin
        d       = q;
        d.ov    = 1'b0;
        d.olast = 1'b0;
        case (q.st)
            ST_IDLE: if (start) begin
                d.st   = ST_RUN;
                d.bin  = '0;
                d.pair = '0;
                if (sym_count == '0)               d.last_pair = '0;
                else if (sym_count > CW'(MAXP))    d.last_pair = PW'(MAXP - 1);
                else                               d.last_pair = PW'(sym_count - 1'b1);
            end
            default: if (in_valid) begin
                if (act) begin
                    d.ov    = 1'b1;
                    d.ore   = comp_out[0];
                    d.oim   = comp_out[1];
                    d.opair = q.pair;
                    d.osub  = sub;
                    d.olast = (q.pair == q.last_pair) && (q.bin == BW'(NFFT - 1));
                end
                d.bin = q.bin + 1'b1;
                if (q.bin == BW'(NFFT - 1)) begin
                    if (q.pair == q.last_pair) d.st = ST_IDLE;
                    else                       d.pair = q.pair + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.ov;
    assign out_re    = q.ore;
    assign out_im    = q.oim;
    assign out_pair  = q.opair;
    assign out_sub   = q.osub;
    assign out_last  = q.olast;

    // R4
    valid_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    // R8
    last_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && out_sub == SUBW'(NACT - 1)));
    // R8
    quiet_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_valid);
    // R7
    pair_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_pair <= q.last_pair));
    // R3
    sub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_sub) < NACT));
endmodule

// File: tb/chest_ls_est_test.sv
module chest_ls_est_test;
    localparam int CLK_P = 10;
    localparam logic [51:0] MASK = 52'h0A605302B3EA6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [4:0] sym_count = '0;
    logic in_valid = 1'b0;
    logic [7:0] in_re = '0, in_im = '0;
    logic out_valid, out_last;
    logic [7:0] out_re, out_im;
    logic [3:0] out_pair;
    logic [5:0] out_sub;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    chest_ls_est uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sym_count(sym_count),
        .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
        .out_pair(out_pair), .out_sub(out_sub), .out_last(out_last)
    );

    function automatic logic [7:0] negsat(logic [7:0] x);
        if (x == 8'h80) return 8'h7F;
        return 8'(-int'($signed(x)));
    endfunction

    task automatic chk(string req, logic ev, logic [7:0] ere, logic [7:0] eim,
                       int ep, int es, logic el);
        logic ok;
        total++;
        if (!ev) ok = (out_valid == 1'b0) && (out_last == 1'b0);
        else ok = out_valid && out_re == ere && out_im == eim &&
                  int'(out_pair) == ep && int'(out_sub) == es && out_last == el;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got v=%0b re=%0d im=%0d pair=%0d sub=%0d last=%0b exp v=%0b re=%0d im=%0d pair=%0d sub=%0d last=%0b",
                     req, out_valid, $signed(out_re), $signed(out_im), out_pair, out_sub, out_last,
                     ev, $signed(ere), $signed(eim), ep, es, el);
        end
    endtask

    task automatic pulse_start(int c);
        @(negedge clk); start = 1'b1; sym_count = 5'(c);
        @(negedge clk); start = 1'b0;
    endtask

    // drives drive_p symbols; eff = symbols the block should honour
    task automatic run(string req, int eff, int drive_p, int mode, int gap, bit restart);
        for (int p = 0; p < drive_p; p++) begin
            for (int b = 0; b < 64; b++) begin
                logic [7:0] r, i;
                bit act;
                int s;
                logic ev;
                if (mode == 0) begin
                    r = 8'(p * 37 + b * 3 - 60);
                    i = 8'(b * 11 - p * 5);
                end else begin
                    r = 8'h80;
                    i = b[0] ? 8'h80 : 8'h7F;
                end
                act = (b >= 1 && b <= 26) || b >= 38;
                s = (b <= 26) ? b - 1 : b - 12;
                ev = act && (p < eff);
                // R10: stall cycles, nothing advances and nothing appears
                if (gap != 0 && (b % gap) == 0) begin
                    @(negedge clk); in_valid = 1'b0; in_re = 8'h55; in_im = 8'h55;
                    @(posedge clk); #1;
                    chk("R10", 1'b0, 8'h0, 8'h0, 0, 0, 1'b0);
                end
                @(negedge clk);
                in_valid = 1'b1; in_re = r; in_im = i;
                if (restart && p == 0 && b == 10) begin start = 1'b1; sym_count = 5'd5; end
                else start = 1'b0;
                @(posedge clk); #1;
                if (ev && MASK[s])
                    chk(req, 1'b1, negsat(r), negsat(i), p, s, (p == eff - 1) && b == 63);
                else
                    chk(req, ev, r, i, p, s, (p == eff - 1) && b == 63);
            end
        end
        @(negedge clk); in_valid = 1'b0; start = 1'b0;
    endtask

    task automatic t_reset;
        @(posedge clk); #1;
        chk("R1", 1'b0, 8'h0, 8'h0, 0, 0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", 1'b0, 8'h0, 8'h0, 0, 0, 1'b0);
    endtask

    task automatic t_single;   // R3 R4 R5 R8
        pulse_start(1);
        run("R5", 1, 1, 0, 0, 1'b0);
    endtask

    task automatic t_multi;    // R7 R10
        pulse_start(3);
        run("R7", 3, 3, 0, 7, 1'b0);
    endtask

    task automatic t_sat;      // R6
        pulse_start(2);
        run("R6", 2, 2, 1, 0, 1'b0);
    endtask

    task automatic t_clamp_low;  // R2 then R8 quiet afterwards
        pulse_start(0);
        run("R2", 1, 2, 0, 0, 1'b0);
    endtask

    task automatic t_clamp_high; // R2
        pulse_start(20);
        run("R2", 16, 17, 0, 0, 1'b0);
    endtask

    task automatic t_idle;     // R9 samples without start
        run("R9", 0, 1, 0, 0, 1'b0);
    endtask

    task automatic t_restart;  // R9 start while busy
        pulse_start(2);
        run("R9", 2, 3, 0, 0, 1'b1);
    endtask

    initial begin
        #(CLK_P * 150000);
        total++; bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_multi();
        t_sat();
        t_clamp_low();
        t_clamp_high();
        t_idle();
        t_restart();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule